// File: doc/BRIEF.md
# I2C Master Status Interrupt Combiner

This block holds the status flags of an I2C master's byte engine and folds them into two level-sensitive interrupt lines: one for transfer progress and one for bus faults. The byte engine pulses a per-bit set input when a condition arises and a per-bit clear input when its own completion sequence retires that condition. Software sees the flags as one status word. It controls the interrupts through three enable bits held in control register 2.

Software clears the fault flags by writing status register 1. A bit written 0 clears its fault flag and a bit written 1 leaves it unchanged, so a handler can retire one fault without a read-modify-write race against the others. Progress flags are out of reach of that write. Every pin is a plain control or status signal. There is no streaming data path and so no valid/ready handshake.

Top module: `i2c_status_irq`

## Requirements
- R1: During and directly after reset, the status word, the three enables and both interrupt outputs are 0.
- R2: A set pulse on an implemented flag bit at a clock edge makes that bit read 1 from that edge on, until a clear removes it.
- R3: Start-sent (bit 0), address-done (bit 1) and byte-finished (bit 2) drive `irq_event` high whenever the event enable (control bit 9) is 1.
- R4: Transmit-empty (bit 7) and receive-full (bit 6) drive `irq_event` only when both the buffer enable (control bit 10) and the event enable (control bit 9) are 1; with the buffer enable 0 they have no effect on `irq_event`.
- R5: Ack-failure (bit 10), arbitration-lost (bit 9) and bus-error (bit 8) drive `irq_error` whenever the error enable (control bit 8) is 1.
- R6: A write to status register 1 clears each fault flag (bits 8 to 10) whose data bit is 0 and leaves each fault flag whose data bit is 1 unchanged.
- R7: A write to status register 1 leaves bits 0, 1, 2, 6 and 7 unchanged, whatever the data.
- R8: A clear pulse from the byte engine clears the matching flag at that edge, for progress and fault flags alike.
- R9: When a set pulse and any clear (engine pulse or status-register write) hit the same flag at the same edge, the flag reads 1 afterwards.
- R10: Status bits 3 to 5 and 11 to 15 always read 0, whatever set pulses arrive.
- R11: Each interrupt output is a level. It stays high while any enabled cause is still set, and it falls as soon as the last enabled cause or its enable is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_set | input | 16 | Per-bit set pulses from the byte engine |
| flag_clr | input | 16 | Per-bit clear pulses from the byte engine |
| wr_data | input | 16 | Register write data |
| cr2_wr | input | 1 | Write strobe for control register 2 (enables at bits 10, 9, 8) |
| sr1_wr | input | 1 | Write strobe for status register 1 |
| status_word | output | 16 | Current flag state |
| irq_event | output | 1 | Level interrupt for transfer events |
| irq_error | output | 1 | Level interrupt for bus faults |

## Verification
Two collisions matter. A set pulse can meet a clear of the same flag, and a status-register write can meet an engine event on an unrelated flag. The bench provokes both directly: it raises a fault flag in the same cycle that status register 1 is written with zeros, and it pulses set and clear together on progress flags. A long random phase then overlaps sets, clears, status writes and enable changes freely. Every cycle, the behavioural model judges the outcome by applying its rule that set wins over any clear.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int REG_W = 16;

  // Status bit positions (software decodes these)
  localparam int SB_B   = 0;
  localparam int ADDR_B = 1;
  localparam int BTF_B  = 2;
  localparam int RXNE_B = 6;
  localparam int TXE_B  = 7;
  localparam int BERR_B = 8;
  localparam int ARLO_B = 9;
  localparam int AF_B   = 10;

  // Control register 2 enable positions
  localparam int EN_ERR_B = 8;
  localparam int EN_EVT_B = 9;
  localparam int EN_BUF_B = 10;

  localparam logic [REG_W-1:0] CORE_EVT_M = (REG_W'(1) << SB_B) | (REG_W'(1) << ADDR_B)
                                          | (REG_W'(1) << BTF_B);
  localparam logic [REG_W-1:0] BUF_EVT_M  = (REG_W'(1) << RXNE_B) | (REG_W'(1) << TXE_B);
  localparam logic [REG_W-1:0] FAULT_M    = (REG_W'(1) << BERR_B) | (REG_W'(1) << ARLO_B)
                                          | (REG_W'(1) << AF_B);
  localparam logic [REG_W-1:0] IMPL_M     = CORE_EVT_M | BUF_EVT_M | FAULT_M;

  typedef struct packed {
    logic buf_en;
    logic evt_en;
    logic err_en;
  } irq_en_t;
endpackage

// File: rtl/i2c_irq_flag_bank.sv
module i2c_irq_flag_bank
  import i2c_irq_pkg::*;
#(
  parameter int W = REG_W,
  parameter logic [W-1:0] IMPL = W'(IMPL_M),
  parameter logic [W-1:0] SW_CLEARABLE = W'(FAULT_M)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] hw_clr_i,
  input  logic         sw_wr_i,
  input  logic [W-1:0] sw_data_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] sw_kill;
  assign sw_kill = {W{sw_wr_i}} & ~sw_data_i & SW_CLEARABLE;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic q;
    logic drop;
    assign drop = hw_clr_i[i] | sw_kill[i];
    always_ff @(posedge clk) begin
      if (!rst_n)            q <= 1'b0;
      else if (!IMPL[i])     q <= 1'b0;
      else if (set_i[i])     q <= 1'b1;
      else if (drop)         q <= 1'b0;
    end
    assign flags_o[i] = q;
  end
endmodule

// File: rtl/i2c_irq_enables.sv
module i2c_irq_enables
  import i2c_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_i,
  input  irq_en_t wr_val_i,
  output irq_en_t en_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    en_o <= '0;
    else if (wr_i) en_o <= wr_val_i;
  end
endmodule

// File: rtl/i2c_irq_cause.sv
module i2c_irq_cause
  import i2c_irq_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic [W-1:0] flags_i,
  input  irq_en_t      en_i,
  output logic         evt_o,
  output logic         err_o
);
  logic core_hit, buf_hit, fault_hit;
  always_comb begin
    core_hit  = |(flags_i & W'(CORE_EVT_M));
    buf_hit   = |(flags_i & W'(BUF_EVT_M));
    fault_hit = |(flags_i & W'(FAULT_M));
    evt_o     = en_i.evt_en & (core_hit | (en_i.buf_en & buf_hit));
    err_o     = en_i.err_en & fault_hit;
  end
endmodule

// File: rtl/i2c_status_irq.sv
module i2c_status_irq
  import i2c_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] flag_set,
  input  logic [REG_W-1:0] flag_clr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             cr2_wr,
  input  logic             sr1_wr,
  output logic [REG_W-1:0] status_word,
  output logic             irq_event,
  output logic             irq_error
);
  irq_en_t en_q;
  irq_en_t en_wr;

  assign en_wr.buf_en = wr_data[EN_BUF_B];
  assign en_wr.evt_en = wr_data[EN_EVT_B];
  assign en_wr.err_en = wr_data[EN_ERR_B];

  i2c_irq_enables u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (cr2_wr),
    .wr_val_i (en_wr),
    .en_o     (en_q)
  );

  i2c_irq_flag_bank #(.W(REG_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (flag_set),
    .hw_clr_i  (flag_clr),
    .sw_wr_i   (sr1_wr),
    .sw_data_i (wr_data),
    .flags_o   (status_word)
  );

  i2c_irq_cause #(.W(REG_W)) u_cause (
    .flags_i (status_word),
    .en_i    (en_q),
    .evt_o   (irq_event),
    .err_o   (irq_error)
  );
endmodule

// File: rtl/i2c_status_irq_chk.sv
module i2c_status_irq_chk
  import i2c_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] flag_set,
  input logic [REG_W-1:0] flag_clr,
  input logic [REG_W-1:0] wr_data,
  input logic             sr1_wr,
  input logic [REG_W-1:0] status_word,
  input logic             irq_event,
  input logic             irq_error,
  input irq_en_t          en_q
);
  // R2 and R9: a set pulse always lands, whatever clear meets it
  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_word & $past(flag_set) & IMPL_M) == ($past(flag_set) & IMPL_M)));

  p_event_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_event |-> en_q.evt_en);

  p_buffer_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_event && !en_q.buf_en) |-> ((status_word & CORE_EVT_M) != '0));

  p_error_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_error |-> (en_q.err_en && ((status_word & FAULT_M) != '0)));

  p_zero_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sr1_wr |=> ((status_word & FAULT_M & ~$past(wr_data) & ~$past(flag_set)) == '0));

  p_progress_immune_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sr1_wr && flag_set == '0 && flag_clr == '0)
      |=> ((status_word & (CORE_EVT_M | BUF_EVT_M))
           == $past(status_word & (CORE_EVT_M | BUF_EVT_M))));

  p_engine_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_word & $past(flag_clr) & ~$past(flag_set)) == '0));

  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word & ~IMPL_M) == '0);

  p_error_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_error && !sr1_wr && flag_clr == '0) ##1 $stable(en_q) |-> irq_error);
endmodule

bind i2c_status_irq i2c_status_irq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flag_set    (flag_set),
  .flag_clr    (flag_clr),
  .wr_data     (wr_data),
  .sr1_wr      (sr1_wr),
  .status_word (status_word),
  .irq_event   (irq_event),
  .irq_error   (irq_error),
  .en_q        (en_q)
);

// File: tb/sim_i2c_status_irq.sv
module sim_i2c_status_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] flag_set = '0;
  logic [15:0] flag_clr = '0;
  logic [15:0] wr_data = '0;
  logic        cr2_wr = 1'b0;
  logic        sr1_wr = 1'b0;
  logic [15:0] status_word;
  logic        irq_event, irq_error;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  logic [15:0] m_stat;
  bit          m_buf, m_evt, m_err;

  always #5 clk = ~clk;

  i2c_status_irq u0 (
    .clk(clk), .rst_n(rst_n), .flag_set(flag_set), .flag_clr(flag_clr),
    .wr_data(wr_data), .cr2_wr(cr2_wr), .sr1_wr(sr1_wr),
    .status_word(status_word), .irq_event(irq_event), .irq_error(irq_error)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = '0; m_buf = 0; m_evt = 0; m_err = 0;
    end else begin
      for (int b = 0; b < 16; b++) begin
        bit impl, fault, kill;
        impl  = (b <= 2) || (b >= 6 && b <= 10);
        fault = (b >= 8 && b <= 10);
        kill  = flag_clr[b] || (fault && sr1_wr && !wr_data[b]);
        if (!impl)            m_stat[b] = 1'b0;
        else if (flag_set[b]) m_stat[b] = 1'b1;
        else if (kill)        m_stat[b] = 1'b0;
      end
      if (cr2_wr) begin
        m_buf = wr_data[10]; m_evt = wr_data[9]; m_err = wr_data[8];
      end
    end
  end

  task automatic compare();
    bit e_evt, e_err;
    e_evt = m_evt && ((m_stat[2:0] != 0) || (m_buf && m_stat[7:6] != 0));
    e_err = m_err && (m_stat[10:8] != 0);
    n_cmp++;
    if (status_word !== m_stat || irq_event !== e_evt || irq_error !== e_err) begin
      n_bad++;
      $display("FAIL %s: got stat=%h evt=%b err=%b, expected stat=%h evt=%b err=%b",
               cur_req, status_word, irq_event, irq_error, m_stat, e_evt, e_err);
    end
  endtask

  task automatic cyc(input logic [15:0] s, input logic [15:0] c,
                     input logic [15:0] d, input bit cw, input bit sw);
    flag_set = s; flag_clr = c; wr_data = d; cr2_wr = cw; sr1_wr = sw;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc('0, '0, '0, 0, 0);
  endtask

  initial begin
    cur_req = "R1";
    @(negedge clk); compare();
    @(negedge clk); compare();
    rst_n = 1'b1;
    idle(2);

    cur_req = "R3";
    cyc('0, '0, 16'h0200, 1, 0);
    cyc(16'h0001, '0, '0, 0, 0);
    idle(2);
    cyc('0, 16'h0001, '0, 0, 0);
    cyc(16'h0004, '0, '0, 0, 0);

    cur_req = "R4";
    cyc(16'h0080, 16'h0004, '0, 0, 0);
    idle(1);
    cyc('0, '0, 16'h0600, 1, 0);
    cyc('0, 16'h0080, '0, 0, 0);
    cyc(16'h0040, '0, '0, 0, 0);
    cyc('0, '0, 16'h0200, 1, 0);

    cur_req = "R5";
    cyc(16'h0600, '0, '0, 0, 0);
    cyc('0, '0, 16'h0100, 1, 0);
    idle(1);

    cur_req = "R6";
    cyc('0, '0, 16'hFDFF, 0, 1);
    cyc('0, '0, 16'hFFFF, 0, 1);

    cur_req = "R7";
    cyc(16'h00C7, 16'h0040, '0, 0, 0);
    cyc('0, '0, 16'h0000, 0, 1);
    cyc('0, '0, 16'h0000, 0, 1);

    cur_req = "R9";
    cyc(16'h0100, '0, 16'h0000, 0, 1);
    cyc(16'h0003, 16'h0003, '0, 0, 0);

    cur_req = "R10";
    cyc(16'hFFFF, '0, '0, 0, 0);
    cyc('0, '0, 16'h0700, 1, 0);

    cur_req = "R11";
    idle(3);
    cyc('0, '0, 16'h0000, 1, 0);
    cyc('0, '0, 16'h0700, 1, 0);

    cur_req = "R8";
    cyc('0, 16'h07FF, '0, 0, 0);
    idle(1);

    cur_req = "R2";
    for (int i = 0; i < 600; i++) begin
      logic [15:0] s, c, d;
      s = 16'($urandom) & 16'($urandom);
      c = 16'($urandom) & 16'($urandom) & 16'($urandom);
      d = 16'($urandom);
      cyc(s, c, d, ($urandom % 8) == 0, ($urandom % 4) == 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule